// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a six-pin bidirectional general-purpose I/O port for a small microcontroller core. Each pin has an output data latch and a direction bit. A port read returns the levels seen on the pins, not the latch contents. The CPU reaches the block through a simple command bus. A one-cycle strobe qualifies an operation code, a bit index and a write byte, and read data comes back one clock later with a valid pulse.

Single-bit set and clear commands are read-modify-write operations on the whole port. They take the sampled levels of all six pins, change the addressed bit and write the full word into every latch. A pin that is currently an input therefore has its latch silently overwritten with its present pad level, and that value appears on the pin once it is made an output. Port writes land at the end of the strobe cycle. Reads use pin levels captured one clock earlier, so a read in the cycle right after a write still sees the old pad state.

An option register has two active-low enables. One turns on weak pull-ups for input pins. The other turns on wake-up-on-change, which compares input pins against a snapshot taken at the last port read. A status flag records whether the most recent non-power-on reset was caused by a wake-up.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A port read (op 0) returns, one cycle after the strobe with `rd_valid` high, bits 7..6 as 1 and bits 5..0 as the pin levels captured on the clock edge before the strobe edge. Latch contents are not returned.
- R2: A port write (op 1) loads `bus_wdata[5:0]` into all six latches whatever the direction bits are. `pin_out` always presents the latch contents.
- R3: Bit set (op 2) and bit clear (op 3) load every latch with the sampled pin levels, with bit `bus_bit` forced to 1 or 0. Input pins' latches take their pad level. An index of 6 or 7 writes the sampled levels back unchanged.
- R4: Loading the direction register (op 4) takes `bus_wdata[5:0]`: a 1 makes the pin an input and a 0 an output. `pin_oe` is the inverse, so 0x07 drives bits 5..3.
- R5: When an input pin is switched to output, it drives the value its latch holds at that moment.
- R6: A port read strobed in the cycle right after a port write returns the old pin levels. A read two cycles after the write returns the new levels.
- R7: Power-on reset (`por_n` low) clears the latches and the status flag and sets direction and option to all ones. A soft reset (`soft_rst`) sets direction and option to all ones, keeps the latches, and loads the status flag from `wake_cause`.
- R8: The option register is written by op 5 and read by op 6. Bit 6 low enables pull-ups: then `pin_pu_en` equals the direction bits, and otherwise it is 0.
- R9: With option bit 7 low, `wake_req` is high while any input pin's captured level differs from its snapshot. The snapshot is taken at every port read. Output pins and a high bit 7 never raise it.
- R10: A status read (op 7) returns the wake-reset flag in bit 7 and zeros in bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| soft_rst | input | 1 | Non-power-on reset, active high, synchronous |
| wake_cause | input | 1 | Marks a soft reset as caused by wake-up |
| bus_stb | input | 1 | Command strobe, one cycle per command |
| bus_op | input | 3 | Command code (0 read port .. 7 read status) |
| bus_bit | input | 3 | Bit index for set/clear |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid pulse |
| pin_in | input | 6 | Pad levels |
| pin_out | output | 6 | Output latch values |
| pin_oe | output | 6 | Output enables, high drives |
| pin_pu_en | output | 6 | Weak pull-up enables |
| wake_req | output | 1 | Wake-up-on-change request |

## Verification
Every cycle, the assertions check several properties: the read word matches the pad value from two edges earlier with the upper bits set, whole-port writes and bit-set merges land in the latches, a direction load inverts onto the enables, and a soft reset leaves the latches untouched. The read-after-write hazard cannot be caught by a per-cycle property, and neither can the silent overwrite of an input pin's latch, which only shows up later when that pin turns into an output. The same holds for wake detection against a snapshot and for the status flag across both reset kinds. Only the bench's ordered scenarios with a modelled pad can show these.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GP_PORT_W = 6;
  localparam int GP_REG_W  = 8;
  localparam int GP_IDX_W  = $clog2(GP_REG_W);

  typedef enum logic [2:0] {
    OP_RD_PORT = 3'd0,
    OP_WR_PORT = 3'd1,
    OP_BSET    = 3'd2,
    OP_BCLR    = 3'd3,
    OP_LD_DIR  = 3'd4,
    OP_WR_OPT  = 3'd5,
    OP_RD_OPT  = 3'd6,
    OP_RD_STAT = 3'd7
  } gp_op_e;

  // Pin word widened to register width, unimplemented bits read as one.
  function automatic logic [GP_REG_W-1:0] port_word(input logic [GP_PORT_W-1:0] lvl);
    return {{(GP_REG_W-GP_PORT_W){1'b1}}, lvl};
  endfunction

  // Read-modify-write merge: sampled levels with one bit forced.
  function automatic logic [GP_PORT_W-1:0] rmw_merge(input logic [GP_PORT_W-1:0] smp,
                                                     input logic [GP_IDX_W-1:0]  idx,
                                                     input logic                 val);
    logic [GP_PORT_W-1:0] r;
    r = smp;
    for (int i = 0; i < GP_PORT_W; i++)
      if (idx == GP_IDX_W'(i)) r[i] = val;
    return r;
  endfunction
endpackage

// File: rtl/gpio_pin_sampler.sv
module gpio_pin_sampler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_smp
);
  // Free-running capture: reads and merges use the level from the previous edge.
  always_ff @(posedge clk) pin_smp <= pin_in;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int W      = 6,
  parameter int REG_W  = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst,
  input  logic             wake_cause,
  input  logic             ld_dir,
  input  logic             opt_we,
  input  logic [REG_W-1:0] wdata,
  output logic [W-1:0]     dir,
  output logic [REG_W-1:0] opt,
  output logic             stat_flag
);
  always_ff @(posedge clk) begin
    if (!por_n) begin
      dir       <= '1;
      opt       <= '1;
      stat_flag <= 1'b0;
    end else if (soft_rst) begin
      dir       <= '1;
      opt       <= '1;
      stat_flag <= wake_cause;
    end else begin
      if (ld_dir) dir <= wdata[W-1:0];
      if (opt_we) opt <= wdata;
    end
  end
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch
  import gpio_pkg::*;
#(
  parameter int W     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic             rmw_en,
  input  logic             rmw_val,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_smp,
  output logic [W-1:0]     latch
);
  logic [W-1:0] merged;

  always_comb merged = rmw_merge(pin_smp, bit_idx, rmw_val);

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!por_n)      latch[i] <= 1'b0;
        else if (wr_en)  latch[i] <= wdata[i];
        else if (rmw_en) latch[i] <= merged[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         snap_en,
  input  logic         wake_en,
  input  logic [W-1:0] pin_smp,
  input  logic [W-1:0] dir,
  output logic [W-1:0] diff,
  output logic         wake_req
);
  logic [W-1:0] snap;

  always_ff @(posedge clk) begin
    if (!por_n)       snap <= '0;
    else if (snap_en) snap <= pin_smp;
  end

  always_comb begin
    diff     = (pin_smp ^ snap) & dir;
    wake_req = wake_en & (|diff);
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int PORT_W       = GP_PORT_W,
  parameter int REG_W        = GP_REG_W,
  parameter int OPT_WAKE_BIT = 7,
  parameter int OPT_PU_BIT   = 6,
  parameter int STAT_BIT     = 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              wake_cause,
  input  logic              bus_stb,
  input  logic [2:0]        bus_op,
  input  logic [2:0]        bus_bit,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rd_valid,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu_en,
  output logic              wake_req
);
  localparam int IDX_W = $clog2(REG_W);

  // Named internal events for the checker.
  logic              cmd_live;
  logic              ev_rd_port, ev_wr_port, ev_rmw, ev_ld_dir, ev_wr_opt, ev_rd_opt, ev_rd_stat;
  logic              rmw_val;
  logic [PORT_W-1:0] pin_smp;
  logic [PORT_W-1:0] dir;
  logic [REG_W-1:0]  opt;
  logic              stat_flag;
  logic [PORT_W-1:0] wake_diff;
  logic              wake_en;
  gp_op_e            op;

  always_comb begin
    op         = gp_op_e'(bus_op);
    cmd_live   = bus_stb & por_n & ~soft_rst;
    ev_rd_port = cmd_live & (op == OP_RD_PORT);
    ev_wr_port = cmd_live & (op == OP_WR_PORT);
    ev_rmw     = cmd_live & ((op == OP_BSET) | (op == OP_BCLR));
    rmw_val    = (op == OP_BSET);
    ev_ld_dir  = cmd_live & (op == OP_LD_DIR);
    ev_wr_opt  = cmd_live & (op == OP_WR_OPT);
    ev_rd_opt  = cmd_live & (op == OP_RD_OPT);
    ev_rd_stat = cmd_live & (op == OP_RD_STAT);
    wake_en    = ~opt[OPT_WAKE_BIT];
  end

  gpio_pin_sampler #(.W(PORT_W)) u_smp (
    .clk     (clk),
    .pin_in  (pin_in),
    .pin_smp (pin_smp)
  );

  gpio_cfg_regs #(.W(PORT_W), .REG_W(REG_W)) u_cfg (
    .clk        (clk),
    .por_n      (por_n),
    .soft_rst   (soft_rst),
    .wake_cause (wake_cause),
    .ld_dir     (ev_ld_dir),
    .opt_we     (ev_wr_opt),
    .wdata      (bus_wdata),
    .dir        (dir),
    .opt        (opt),
    .stat_flag  (stat_flag)
  );

  gpio_data_latch #(.W(PORT_W), .IDX_W(IDX_W)) u_lat (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (ev_wr_port),
    .rmw_en  (ev_rmw),
    .rmw_val (rmw_val),
    .bit_idx (bus_bit),
    .wdata   (bus_wdata[PORT_W-1:0]),
    .pin_smp (pin_smp),
    .latch   (pin_out)
  );

  gpio_wake_detect #(.W(PORT_W)) u_wk (
    .clk      (clk),
    .por_n    (por_n),
    .snap_en  (ev_rd_port),
    .wake_en  (wake_en),
    .pin_smp  (pin_smp),
    .dir      (dir),
    .diff     (wake_diff),
    .wake_req (wake_req)
  );

  always_comb begin
    pin_oe    = ~dir;
    pin_pu_en = opt[OPT_PU_BIT] ? '0 : dir;
  end

  always_ff @(posedge clk) begin
    if (!por_n || soft_rst) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= ev_rd_port | ev_rd_opt | ev_rd_stat;
      if (ev_rd_port)      bus_rdata <= port_word(pin_smp);
      else if (ev_rd_opt)  bus_rdata <= opt;
      else if (ev_rd_stat) begin
        bus_rdata           <= '0;
        bus_rdata[STAT_BIT] <= stat_flag;
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int PORT_W = 6,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              soft_rst,
  input logic              bus_stb,
  input logic [2:0]        bus_op,
  input logic [2:0]        bus_bit,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              rd_valid,
  input logic [PORT_W-1:0] pin_in,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_smp
);
  logic live;
  assign live = bus_stb && !soft_rst;

  a_r1_upper_ones: assert property (@(posedge clk) disable iff (!por_n)
    (live && bus_op == 3'd0) |=> (rd_valid && bus_rdata[REG_W-1:PORT_W] == '1));

  a_r6_read_lags: assert property (@(posedge clk) disable iff (!por_n)
    (live && bus_op == 3'd0) |=> (bus_rdata[PORT_W-1:0] == $past(pin_in, 2)));

  a_r2_write_all: assert property (@(posedge clk) disable iff (!por_n)
    (live && bus_op == 3'd1) |=> (pin_out == $past(bus_wdata[PORT_W-1:0])));

  a_r3_set_merge: assert property (@(posedge clk) disable iff (!por_n)
    (live && bus_op == 3'd2 && bus_bit < 3'(PORT_W)) |=>
      (pin_out == ($past(pin_smp) | (PORT_W'(1) << $past(bus_bit)))));

  a_r4_dir_to_oe: assert property (@(posedge clk) disable iff (!por_n || soft_rst)
    (live && bus_op == 3'd4) |=> (pin_oe == ~$past(bus_wdata[PORT_W-1:0])));

  a_r7_soft_keeps: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> $stable(pin_out));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PORT_W(PORT_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .soft_rst  (soft_rst),
  .bus_stb   (bus_stb),
  .bus_op    (bus_op),
  .bus_bit   (bus_bit),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rd_valid  (rd_valid),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_smp   (pin_smp)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, soft_rst = 1'b0, wake_cause = 1'b0;
  logic       bus_stb = 1'b0;
  logic [2:0] bus_op = 3'd0, bus_bit = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rd_valid;
  logic [5:0] ext = 6'h2A;
  logic [5:0] pad, pin_out, pin_oe, pin_pu_en;
  logic       wake_req;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  // Pad model: driven pins show the latch, others show the external level.
  assign pad = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_port_ctrl u_dut (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wake_cause(wake_cause),
    .bus_stb(bus_stb), .bus_op(bus_op), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rd_valid(rd_valid), .pin_in(pad),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu_en(pin_pu_en), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pop expected read words as the design returns them.
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("unexpected read", bus_rdata, 8'hxx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [2:0] b, input logic [7:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_op = op; bus_bit = b; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  task automatic rd(input logic [2:0] op, input logic [7:0] exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    cmd(op, 3'd0, 8'h00);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    por_n = 1'b1;
    idle(2);
    // R7 / R4 power-on state
    check("R7 latch after por", {2'b0, pin_out}, 8'h00);
    check("R4 no drive after por", {2'b0, pin_oe}, 8'h00);
    check("R8 pull-up off at reset", {2'b0, pin_pu_en}, 8'h00);
    rd(3'd6, 8'hFF, "R8 option reset value");
    rd(3'd7, 8'h00, "R10 status after por");
    rd(3'd0, 8'hEA, "R1 read pins with ones above");

    // R2 write lands even though all pins are inputs
    cmd(3'd1, 3'd0, 8'h15);
    check("R2 latch written while input", {2'b0, pin_out}, 8'h15);
    rd(3'd0, 8'hEA, "R1 read returns pins not latch");

    // R4 dir 0x07: bits 5..3 driven
    cmd(3'd4, 3'd0, 8'h07);
    check("R4 oe from dir 0x07", {2'b0, pin_oe}, 8'h38);
    idle(1);
    rd(3'd0, 8'hD2, "R1 mixed pad read");

    // R3 clear bit5: inputs' latches take pad levels 010
    cmd(3'd3, 3'd5, 8'h00);
    check("R3 clear overwrites input latches", {2'b0, pin_out}, 8'h12);
    idle(1);
    cmd(3'd2, 3'd3, 8'h00);
    check("R3 set bit3 merge", {2'b0, pin_out}, 8'h1A);
    // R5 now all outputs: drive latch
    cmd(3'd4, 3'd0, 8'h00);
    check("R5 oe all", {2'b0, pin_oe}, 8'h3F);
    idle(1);
    rd(3'd0, 8'hDA, "R5 pins drive latched value");

    // R3 unimplemented index: write back sampled pins
    cmd(3'd4, 3'd0, 8'h3F);
    ext = 6'h05;
    idle(2);
    cmd(3'd2, 3'd7, 8'h00);
    check("R3 index 7 writes back pins", {2'b0, pin_out}, 8'h05);

    // R6 read right after write sees old level
    cmd(3'd4, 3'd0, 8'h00);
    idle(2);
    exp_q.push_back(8'hC5); tag_q.push_back("R6 read after write is old");
    @(negedge clk);
    bus_stb = 1'b1; bus_op = 3'd1; bus_wdata = 8'h3A;
    @(negedge clk);
    bus_op = 3'd0; bus_wdata = 8'h00;
    @(negedge clk);
    bus_stb = 1'b0;
    idle(1);
    rd(3'd0, 8'hFA, "R6 later read is new");

    // R8 pull-ups follow direction when enabled
    cmd(3'd5, 3'd0, 8'hBF);
    check("R8 pull-up none on outputs", {2'b0, pin_pu_en}, 8'h00);
    cmd(3'd4, 3'd0, 8'h0F);
    check("R8 pull-up on inputs", {2'b0, pin_pu_en}, 8'h0F);
    rd(3'd6, 8'hBF, "R8 option readback");

    // R9 wake on change of input pins
    idle(2);
    rd(3'd0, 8'hF5, "R9 snapshot read");
    cmd(3'd5, 3'd0, 8'h3F);
    check("R9 no wake when equal", {7'b0, wake_req}, 8'h00);
    ext = 6'h15;           // bit4 is an output pin
    idle(3);
    check("R9 output pin change ignored", {7'b0, wake_req}, 8'h00);
    ext = 6'h14;           // bit0 input changes
    idle(2);
    check("R9 wake on input change", {7'b0, wake_req}, 8'h01);
    rd(3'd0, 8'hF4, "R9 read refreshes snapshot");
    check("R9 wake clears after read", {7'b0, wake_req}, 8'h00);
    cmd(3'd5, 3'd0, 8'hBF);
    ext = 6'h15;
    idle(3);
    check("R9 wake disabled", {7'b0, wake_req}, 8'h00);

    // R7 soft reset keeps latch, records cause
    @(negedge clk); wake_cause = 1'b1; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; wake_cause = 1'b0;
    idle(1);
    check("R7 soft reset keeps latch", {2'b0, pin_out}, 8'h3A);
    check("R7 soft reset dir ones", {2'b0, pin_oe}, 8'h00);
    rd(3'd7, 8'h80, "R10 status wake flag");
    rd(3'd6, 8'hFF, "R7 option after soft reset");
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    idle(1);
    rd(3'd7, 8'h00, "R10 status plain soft reset");
    @(negedge clk); por_n = 1'b0;
    idle(2); por_n = 1'b1;
    idle(1);
    check("R7 por clears latch", {2'b0, pin_out}, 8'h00);

    idle(3);
    if (exp_q.size() != 0) check("R1 reads left pending", 8'(exp_q.size()), 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule